// File: doc/BRIEF.md
# Burst ADC Scan Sequencer

This block is the digital half of a multi-channel successive-approximation converter that runs as a free-running scanner. It divides the peripheral clock down to a conversion clock and visits every enabled input in ascending order, wrapping back to the lowest one. For each input it drives the analog multiplexer, presents trial codes to an external comparator and resolves the result one bit per conversion clock. Every finished value is published twice: to a shared result register and to a register reserved for that input.

The shared register takes the finished code and the number of the input it belongs to in the same clock edge. The tag therefore stays correct after the scanner moves to the next input one conversion clock later. A consumer that reads late still gets a matching code and tag. A read strobe clears the shared done flag. A result that lands while the previous one is still unread raises an overrun flag.

Top module: `adc_burst_seq`

## Requirements
- R1: One conversion clock lasts `clkDiv`+1 peripheral cycles. A conversion lasts 65 conversion clocks, so the first done flag appears exactly 65*(`clkDiv`+1) cycles after the edge that starts the scan.
- R2: While the scan is enabled, the enabled inputs (bit i of `chanMask` set means input i is enabled) are converted in ascending index order and the order wraps around. `muxSel` shows the input being converted.
- R3: The trial code is resolved from MSB to LSB, one bit per conversion clock. A bit stays 1 when `cmpIn` is 1 (the input is at or above the trial level) at the end of that clock, and is cleared otherwise. The published code is therefore the largest code not above the input level.
- R4: The shared result and tag change only when a conversion finishes, which sets the done flag. They hold steady while the next conversion shows intermediate trial codes on `trialCode`.
- R5: `muxSel` moves to the next enabled input exactly one conversion clock (`clkDiv`+1 cycles) after the done flag rises.
- R6: `globalChan` keeps the tag of the finished conversion after `muxSel` has moved on.
- R7: Each finished code is also written to that input's slice `chanResult[i*10 +: 10]`, and its bit in `chanDone` is set. That bit only ever rises.
- R8: A one-cycle `globalRd` pulse clears `globalDone` and `globalOverrun` at the next edge. `globalDone` never falls without a read.
- R9: If a result is published while `globalDone` is still set and unread, `globalOverrun` is set.
- R10: When `burstEn` is cleared, the running conversion completes and publishes, and no further conversion starts.
- R11: `divInvalid` is 1 when the peripheral frequency divided by `clkDiv`+1 exceeds 13 MHz (with 100 MHz, `clkDiv` below 7). No conversion starts while it is set.
- R12: After reset all flags, codes, tags and `muxSel` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Active-low synchronous reset |
| burstEn | input | 1 | Enables free-running scanning |
| chanMask | input | NUM_CH | Bit i enables input i |
| clkDiv | input | DIV_W | Conversion clock divider minus one |
| cmpIn | input | 1 | Comparator decision for the current trial code |
| globalRd | input | 1 | Read strobe for the shared result register |
| trialCode | output | RES_BITS | Trial code sent to the DAC/comparator |
| muxSel | output | CHW | Analog multiplexer select |
| globalResult | output | RES_BITS | Last published code |
| globalChan | output | CHW | Input number of the last published code |
| globalDone | output | 1 | Unread result present |
| globalOverrun | output | 1 | A result was overwritten before being read |
| chanResult | output | NUM_CH*RES_BITS | Per-input result registers, input i at bits i*RES_BITS upward |
| chanDone | output | NUM_CH | Per-input result-present bits |
| divInvalid | output | 1 | Divider gives a conversion clock above the limit |

## Verification
A wrong phase counter or divider shows up as a first done flag on the wrong cycle, or as `muxSel` moving earlier or later than one conversion clock after done. Either is visible at the first conversion. A wrong channel pointer shows up within one scan as a tag or code that does not match the queued expectation. An unlatched tag shows up `clkDiv`+1 cycles after done, when `globalChan` follows `muxSel`. Errors in the done, read and overrun flags appear on the next publish or read.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_CONV = 2'd1,
    SEQ_GAP  = 2'd2
  } seqState_t;

  typedef struct packed {
    logic startConv;
    logic resolveBit;
    logic publish;
  } seqStrobe_t;
endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int RES_BITS   = 10,
  parameter int CONV_CLKS  = 65,
  parameter int DIV_W      = 8,
  parameter int PCLK_HZ    = 100_000_000,
  parameter int MAX_ADC_HZ = 13_000_000,
  localparam int CHW       = $clog2(NUM_CH),
  localparam int BIT_W     = $clog2(RES_BITS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               burstEn,
  input  logic [NUM_CH-1:0]  chanMask,
  input  logic [DIV_W-1:0]   clkDiv,
  output seqStrobe_t         strobe,
  output logic [BIT_W-1:0]   bitSel,
  output logic [CHW-1:0]     curChan,
  output logic               divInvalid
);
  localparam int CNT_W     = $clog2(CONV_CLKS);
  localparam int LAST_BIT  = CONV_CLKS - 2;
  localparam int FIRST_BIT = LAST_BIT - RES_BITS + 1;
  localparam int MIN_DIVP1 = (PCLK_HZ + MAX_ADC_HZ - 1) / MAX_ADC_HZ;

  seqState_t         state;
  logic [DIV_W-1:0]  divCnt;
  logic [CNT_W-1:0]  phaseCnt;
  logic              tick;
  logic              canStart;

  function automatic logic [CHW-1:0] lowestChan(input logic [NUM_CH-1:0] m);
    logic [CHW-1:0] r;
    r = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (m[i]) r = CHW'(i);
    end
    return r;
  endfunction

  function automatic logic [CHW-1:0] nextChan(input logic [NUM_CH-1:0] m,
                                              input logic [CHW-1:0] c);
    logic [CHW-1:0] r;
    int idx;
    r = c;
    for (int k = NUM_CH - 1; k >= 1; k--) begin
      idx = (int'(c) + k) % NUM_CH;
      if (m[idx]) r = CHW'(idx);
    end
    return r;
  endfunction

  assign divInvalid = (int'(clkDiv) + 1) < MIN_DIVP1;
  assign canStart   = burstEn && !divInvalid && (|chanMask);
  assign tick       = (state != SEQ_IDLE) && (divCnt >= clkDiv);

  always_comb begin
    strobe.startConv  = ((state == SEQ_IDLE) && canStart) ||
                        ((state == SEQ_GAP) && tick && canStart);
    strobe.resolveBit = (state == SEQ_CONV) && tick &&
                        (int'(phaseCnt) >= FIRST_BIT) && (int'(phaseCnt) <= LAST_BIT);
    strobe.publish    = (state == SEQ_CONV) && tick &&
                        (int'(phaseCnt) == CONV_CLKS - 1);
    bitSel            = BIT_W'(LAST_BIT - int'(phaseCnt));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= SEQ_IDLE;
      divCnt   <= '0;
      phaseCnt <= '0;
      curChan  <= '0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          divCnt   <= '0;
          phaseCnt <= '0;
          if (canStart) begin
            state   <= SEQ_CONV;
            curChan <= lowestChan(chanMask);
          end
        end
        SEQ_CONV: begin
          divCnt <= tick ? '0 : divCnt + 1'b1;
          if (tick) begin
            if (int'(phaseCnt) == CONV_CLKS - 1) state <= SEQ_GAP;
            else phaseCnt <= phaseCnt + 1'b1;
          end
        end
        default: begin
          divCnt <= tick ? '0 : divCnt + 1'b1;
          if (tick) begin
            phaseCnt <= '0;
            if (|chanMask) curChan <= nextChan(chanMask, curChan);
            state <= canStart ? SEQ_CONV : SEQ_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_datapath.sv
module adc_seq_datapath
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int RES_BITS = 10,
  localparam int CHW     = $clog2(NUM_CH),
  localparam int BIT_W   = $clog2(RES_BITS)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  seqStrobe_t                   strobe,
  input  logic [BIT_W-1:0]             bitSel,
  input  logic [CHW-1:0]               curChan,
  input  logic                         cmpIn,
  input  logic                         globalRd,
  output logic [RES_BITS-1:0]          trialCode,
  output logic [RES_BITS-1:0]          globalResult,
  output logic [CHW-1:0]               globalChan,
  output logic                         globalDone,
  output logic                         globalOverrun,
  output logic [NUM_CH*RES_BITS-1:0]   chanResult,
  output logic [NUM_CH-1:0]            chanDone
);
  logic [RES_BITS-1:0] sar;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sar <= '0;
    end else if (strobe.startConv) begin
      sar <= {1'b1, {(RES_BITS-1){1'b0}}};
    end else if (strobe.resolveBit) begin
      sar[bitSel] <= cmpIn;
      if (bitSel != '0) sar[bitSel - 1'b1] <= 1'b1;
    end
  end

  assign trialCode = sar;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      globalResult  <= '0;
      globalChan    <= '0;
      globalDone    <= 1'b0;
      globalOverrun <= 1'b0;
    end else if (strobe.publish) begin
      globalResult  <= sar;
      globalChan    <= curChan;
      globalDone    <= 1'b1;
      globalOverrun <= globalDone && !globalRd;
    end else if (globalRd) begin
      globalDone    <= 1'b0;
      globalOverrun <= 1'b0;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : gChanReg
    logic [RES_BITS-1:0] chRes;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        chRes       <= '0;
        chanDone[i] <= 1'b0;
      end else if (strobe.publish && (int'(curChan) == i)) begin
        chRes       <= sar;
        chanDone[i] <= 1'b1;
      end
    end
    assign chanResult[i*RES_BITS +: RES_BITS] = chRes;
  end
endmodule

// File: rtl/adc_burst_seq.sv
module adc_burst_seq
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int RES_BITS   = 10,
  parameter int CONV_CLKS  = 65,
  parameter int DIV_W      = 8,
  parameter int PCLK_HZ    = 100_000_000,
  parameter int MAX_ADC_HZ = 13_000_000,
  localparam int CHW       = $clog2(NUM_CH),
  localparam int BIT_W     = $clog2(RES_BITS)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        burstEn,
  input  logic [NUM_CH-1:0]           chanMask,
  input  logic [DIV_W-1:0]            clkDiv,
  input  logic                        cmpIn,
  input  logic                        globalRd,
  output logic [RES_BITS-1:0]         trialCode,
  output logic [CHW-1:0]              muxSel,
  output logic [RES_BITS-1:0]         globalResult,
  output logic [CHW-1:0]              globalChan,
  output logic                        globalDone,
  output logic                        globalOverrun,
  output logic [NUM_CH*RES_BITS-1:0]  chanResult,
  output logic [NUM_CH-1:0]           chanDone,
  output logic                        divInvalid
);
  seqStrobe_t        strobe;
  logic [BIT_W-1:0]  bitSel;

  adc_seq_ctrl #(
    .NUM_CH(NUM_CH), .RES_BITS(RES_BITS), .CONV_CLKS(CONV_CLKS),
    .DIV_W(DIV_W), .PCLK_HZ(PCLK_HZ), .MAX_ADC_HZ(MAX_ADC_HZ)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .burstEn(burstEn), .chanMask(chanMask),
    .clkDiv(clkDiv), .strobe(strobe), .bitSel(bitSel),
    .curChan(muxSel), .divInvalid(divInvalid)
  );

  adc_seq_datapath #(
    .NUM_CH(NUM_CH), .RES_BITS(RES_BITS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .bitSel(bitSel),
    .curChan(muxSel), .cmpIn(cmpIn), .globalRd(globalRd),
    .trialCode(trialCode), .globalResult(globalResult),
    .globalChan(globalChan), .globalDone(globalDone),
    .globalOverrun(globalOverrun), .chanResult(chanResult),
    .chanDone(chanDone)
  );
endmodule

// File: rtl/adc_burst_seq_chk.sv
module adc_burst_seq_chk #(
  parameter int NUM_CH   = 4,
  parameter int RES_BITS = 10,
  localparam int CHW     = $clog2(NUM_CH)
) (
  input logic                clk,
  input logic                rstN,
  input logic                globalRd,
  input logic                globalDone,
  input logic                globalOverrun,
  input logic [RES_BITS-1:0] globalResult,
  input logic [CHW-1:0]      globalChan,
  input logic [NUM_CH-1:0]   chanDone
);
  AST_RESULT_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (globalResult != $past(globalResult)) |-> globalDone); // R4
  AST_TAG_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (globalChan != $past(globalChan)) |-> globalDone); // R6
  AST_DONE_FALLS_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    $fell(globalDone) |-> $past(globalRd)); // R8
  AST_OVERRUN_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    globalOverrun |-> globalDone); // R9
  AST_CHAN_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (($past(chanDone) & ~chanDone) == '0)); // R7
endmodule

bind adc_burst_seq adc_burst_seq_chk #(.NUM_CH(NUM_CH), .RES_BITS(RES_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .globalRd(globalRd), .globalDone(globalDone),
  .globalOverrun(globalOverrun), .globalResult(globalResult),
  .globalChan(globalChan), .chanDone(chanDone)
);

// File: tb/tb_adc_burst_seq.sv
module tb_adc_burst_seq;
  localparam int NCH = 4;
  localparam int RB  = 10;
  localparam int DIVV = 7;
  localparam int PER = DIVV + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic burstEn = 1'b0;
  logic [NCH-1:0] chanMask = '0;
  logic [7:0] clkDiv = 8'd7;
  logic cmpIn;
  logic monRd = 1'b0, mainRd = 1'b0;
  logic globalRd;
  logic [RB-1:0] trialCode, globalResult;
  logic [1:0] muxSel, globalChan;
  logic globalDone, globalOverrun, divInvalid;
  logic [NCH*RB-1:0] chanResult;
  logic [NCH-1:0] chanDone;

  logic [RB-1:0] vin [NCH];
  int expQ[$];
  int nChecks = 0, nFails = 0;
  bit monEn = 1'b0;
  bit finished = 1'b0;
  int k = -1;
  int lastCh = 0, lastVal = 0;

  always #2.5 clk = ~clk;

  assign globalRd = monRd | mainRd;
  assign cmpIn = (trialCode <= vin[muxSel]);

  adc_burst_seq dut (
    .clk(clk), .rstN(rstN), .burstEn(burstEn), .chanMask(chanMask),
    .clkDiv(clkDiv), .cmpIn(cmpIn), .globalRd(globalRd),
    .trialCode(trialCode), .muxSel(muxSel), .globalResult(globalResult),
    .globalChan(globalChan), .globalDone(globalDone),
    .globalOverrun(globalOverrun), .chanResult(chanResult),
    .chanDone(chanDone), .divInvalid(divInvalid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pushScan(input int ch);
    expQ.push_back(ch);
  endtask

  // Monitor: pops one expected input per published result and follows it up
  always @(negedge clk) begin
    if (monEn) begin
      if (k >= 0) begin
        k++;
        if (k == 1) begin
          monRd = 1'b0;
          check(globalDone == 1'b0, "R8 done cleared by read", int'(globalDone), 0);
        end
        if (k == DIVV) check(int'(muxSel) == lastCh, "R5 mux held", int'(muxSel), lastCh);
        if (k == DIVV + 1) begin
          if ($countones(chanMask) > 1)
            check(int'(muxSel) != lastCh, "R5 mux advanced", int'(muxSel), lastCh);
          check(int'(globalChan) == lastCh, "R6 tag latched", int'(globalChan), lastCh);
        end
        if (k == 300) begin
          check(int'(globalResult) == lastVal, "R4 result stable", int'(globalResult), lastVal);
          k = -1;
        end
      end else if (globalDone) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R10 unexpected result", int'(globalChan), -1);
        end else begin
          lastCh = expQ.pop_front();
          lastVal = int'(vin[lastCh]);
          check(int'(globalChan) == lastCh, "R2 scan order", int'(globalChan), lastCh);
          check(int'(globalResult) == lastVal, "R3 code", int'(globalResult), lastVal);
          check(int'(muxSel) == lastCh, "R6 tag equals mux at done", int'(muxSel), lastCh);
        end
        monRd = 1'b1;
        k = 0;
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    vin[0] = 10'd300; vin[1] = 10'd700; vin[2] = 10'd1023; vin[3] = 10'd0;

    repeat (5) @(negedge clk);
    check(globalDone == 0 && globalOverrun == 0, "R12 flags", int'({globalDone, globalOverrun}), 0);
    check(trialCode == 0 && muxSel == 0 && globalChan == 0, "R12 codes", int'(trialCode), 0);
    check(chanDone == 0 && globalResult == 0, "R12 channel regs", int'(chanDone), 0);
    rstN = 1'b1;

    // R11: divider too small
    @(negedge clk);
    clkDiv = 8'd6; chanMask = 4'b1011;
    @(negedge clk);
    check(divInvalid == 1'b1, "R11 invalid at 6", int'(divInvalid), 1);
    burstEn = 1'b1;
    repeat (600) @(negedge clk);
    check(globalDone == 1'b0 && trialCode == 0, "R11 no conversion", int'(globalDone), 0);
    burstEn = 1'b0;
    clkDiv = 8'd7;
    @(negedge clk);
    check(divInvalid == 1'b0, "R11 valid at 7", int'(divInvalid), 0);

    // R1 R2 R3: scan 0,1,3 with wrap
    pushScan(0); pushScan(1); pushScan(3); pushScan(0); pushScan(1);
    monEn = 1'b1;
    burstEn = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!globalDone && n < 2000);
    check(n == 65 * PER + 1, "R1 first done timing", n, 65 * PER + 1);
    while (expQ.size() != 0) @(negedge clk);

    // R10: stop during a running conversion (input 3)
    repeat (20) @(negedge clk);
    pushScan(3);
    burstEn = 1'b0;
    repeat (1300) @(negedge clk);
    check(expQ.size() == 0, "R10 last conversion completed", expQ.size(), 0);
    monEn = 1'b0;

    // R7: per-input registers
    check(chanDone == 4'b1011, "R7 done bits", int'(chanDone), 11);
    for (int c = 0; c < NCH; c++) begin
      if (c != 2)
        check(chanResult[c*RB +: RB] == vin[c], "R7 per-input code",
              int'(chanResult[c*RB +: RB]), int'(vin[c]));
    end

    // R9: overrun on a single-input scan without reads
    chanMask = 4'b0100;
    burstEn = 1'b1;
    repeat (1100) @(negedge clk);
    check(globalOverrun == 1'b1, "R9 overrun set", int'(globalOverrun), 1);
    check(globalDone == 1'b1 && globalChan == 2'd2, "R9 latest tag", int'(globalChan), 2);
    check(globalResult == 10'd1023, "R3 full-scale code", int'(globalResult), 1023);
    mainRd = 1'b1;
    @(negedge clk);
    mainRd = 1'b0;
    check(globalDone == 0 && globalOverrun == 0, "R8 read clears", int'({globalDone, globalOverrun}), 0);
    burstEn = 1'b0;
    repeat (600) @(negedge clk);
    check(chanDone == 4'b1111, "R7 all done bits", int'(chanDone), 15);
    check(chanResult[2*RB +: RB] == 10'd1023, "R7 input 2 code", int'(chanResult[2*RB +: RB]), 1023);

    finish_run();
  end
endmodule